// File: doc/BRIEF.md
# Alarm, Timer and Pulse Interrupt Controller

This block holds the three interrupt flags of a real-time clock and drives its interrupt request line. The flags are for a periodic pulse, a calendar alarm and an elapsed-time timer. The block samples its event conditions on the 10 ms update tick, which comes from the clock's divider chain. The time counters, the divider and the timer are outside this block. It receives their current values as inputs: the five BCD clock fields, a strobe for timer rollover, and strobes for the 100 ms, 1 s and 1 min periods.

Software sets the enable, mask and rate-select bits, which reach the block as register inputs. It acknowledges an interrupt by writing zero to the flag position in the flag/mask register. The interrupt pin is an active-low open-drain output. It is modelled as a level plus an output enable. A standby input models the power-fail state. In standby only the alarm may pull the line.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset all three flags are 0, `irq_oe` is 0 and `irq_n` is 1.
- R2: `irq_oe` is 1 exactly when some flag is 1 and its mask bit in `irq_mask` is 1. Mask bit 0 belongs to pulse, 1 to alarm and 2 to timer, and the pulse and timer terms are gated by standby. `irq_n` is always the inverse of `irq_oe`. A flag stays at 1 until it is cleared.
- R3: A cycle with `clr_we` high clears a flag when its bit in `clr_data` is 0. The bits are 4 for pulse, 5 for alarm and 6 for timer. A 1 in that bit leaves the flag unchanged.
- R4: `pulse_sel` bits 0, 1, 2 and 3 choose the pulse period: every tick, `per_100ms`, `per_1s` or `per_1min`. When exactly one bit is set, the pulse flag sets on a tick where the selected strobe is high. When no bit or more than one bit is set, no pulse is generated.
- R5: Each source needs its enable bit in `ctrl`. Bit 1 enables pulse, bit 2 alarm and bit 3 timer. With its enable at 0, a source never sets its flag.
- R6: The alarm flag sets on a tick when hundredths, seconds, minutes, hours and date of `alm_time` all equal `cur_time`. Field k occupies bits 8k+7:8k, with hundredths at k=0 and date at k=4. An alarm field equal to FF hex is ignored in the comparison.
- R7: The timer flag sets on a tick where `tmr_roll` is high, and at no other time.
- R8: In standby no pulse event occurs, and the pulse and timer flags do not drive `irq_oe`. The timer flag can still be set. A set alarm flag with its mask bit set still drives `irq_oe`.
- R9: If a flag's set event and a clear write to it fall in the same cycle, the flag ends at 1.
- R10: When standby ends, pulse generation resumes with the enable and rate bits that were present before.
- R11: A flag changes on the first rising clock edge that samples the event or the clear. `irq_oe` follows flags, masks and standby with no further register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 10 ms update strobe, one cycle wide |
| stby | input | 1 | Standby (power-fail) state |
| per_100ms | input | 1 | 100 ms period strobe, valid with tick |
| per_1s | input | 1 | 1 s period strobe, valid with tick |
| per_1min | input | 1 | 1 min period strobe, valid with tick |
| tmr_roll | input | 1 | Timer rolls from 23:59:59.99 to zero, valid with tick |
| ctrl | input | 8 | Control register: bit1 pulse enable, bit2 alarm enable, bit3 timer enable |
| pulse_sel | input | 4 | One-hot pulse period select |
| irq_mask | input | 3 | Mask bits: 0 pulse, 1 alarm, 2 timer |
| cur_time | input | 40 | Clock fields, packed BCD, hundredths in the lowest byte |
| alm_time | input | 40 | Alarm fields, same layout, FF hex = don't care |
| clr_we | input | 1 | Write strobe to the flag register |
| clr_data | input | 8 | Write data; 0 in bit 4/5/6 clears that flag |
| flags | output | 3 | Flags: 0 pulse, 1 alarm, 2 timer |
| irq_n | output | 1 | Interrupt level, active low |
| irq_oe | output | 1 | Open-drain driver enable |

## Verification
Each flag is due on the first rising edge after the cycle that presents the tick, the rollover or the clear write. `irq_oe` is due in the same cycle as the flag it follows, and when a mask or standby changes it is due at once. The bench changes inputs one time unit after an edge and samples one time unit after the next edge. One check reads the flags just before the edge that samples an event and expects the old value, which confirms the single-register latency.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int FW     = 8,
  parameter int NFIELD = 5,
  parameter int NRATE  = 4,
  parameter int NSRC   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 stby,
  input  logic                 per_100ms,
  input  logic                 per_1s,
  input  logic                 per_1min,
  input  logic                 tmr_roll,
  input  logic [7:0]           ctrl,
  input  logic [NRATE-1:0]     pulse_sel,
  input  logic [NSRC-1:0]      irq_mask,
  input  logic [NFIELD*FW-1:0] cur_time,
  input  logic [NFIELD*FW-1:0] alm_time,
  input  logic                 clr_we,
  input  logic [7:0]           clr_data,
  output logic [NSRC-1:0]      flags,
  output logic                 irq_n,
  output logic                 irq_oe
);
  localparam int FLAG_LSB = 4;
  localparam int EN_LSB   = 1;
  localparam logic [FW-1:0] WILD = '1;

  logic [NFIELD-1:0] fld_ok;
  logic [NRATE-1:0]  rate_hit;
  logic [NSRC-1:0]   ev, clr, nxt, gate;
  logic              alm_match, sel_ok;

  for (genvar k = 0; k < NFIELD; k++) begin : g_fld
    wire [FW-1:0] a = alm_time[k*FW +: FW];
    assign fld_ok[k] = (a == WILD) || (a == cur_time[k*FW +: FW]);
  end

  assign alm_match = &fld_ok;
  assign rate_hit  = {per_1min, per_1s, per_100ms, 1'b1};
  assign sel_ok    = $onehot(pulse_sel);

  assign ev[0] = tick & ctrl[EN_LSB]   & ~stby & sel_ok & |(pulse_sel & rate_hit);
  assign ev[1] = tick & ctrl[EN_LSB+1] & alm_match;
  assign ev[2] = tick & ctrl[EN_LSB+2] & tmr_roll;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    assign clr[i] = clr_we & ~clr_data[FLAG_LSB+i];
    assign nxt[i] = ev[i] | (flags[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= nxt;

  assign gate   = {~stby, 1'b1, ~stby};
  assign irq_oe = |(flags & irq_mask & gate);
  assign irq_n  = ~irq_oe;

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> flags == '0);
  a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !clr_we) |=> flags[2]);
  a_r3_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !clr_data[5] && !tick) |=> !flags[1]);
  a_r4_bad_sel_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!$onehot(pulse_sel) && !flags[0]) |=> !flags[0]);
  a_r7_timer_only_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[2] && !(tick && tmr_roll)) |=> !flags[2]);
  a_r8_standby_alarm_only: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && irq_oe) |-> (flags[1] && irq_mask[1]));
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl[2] && alm_match && clr_we) |=> flags[1]);
  a_r2_pin_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n != irq_oe);
endmodule

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic tick = 0, stby = 0, per_100ms = 0, per_1s = 0, per_1min = 0, tmr_roll = 0;
  logic [7:0] ctrl = 0, clr_data = 8'hFF;
  logic [3:0] pulse_sel = 0;
  logic [2:0] irq_mask = 0;
  logic [39:0] cur_time = 0, alm_time = 0;
  logic clr_we = 0;
  logic [2:0] flags;
  logic irq_n, irq_oe;
  int n_run = 0, n_fail = 0;

  localparam logic [39:0] NOW = {8'h12, 8'h07, 8'h30, 8'h45, 8'h50};

  always #4 clk = ~clk;

  rtc_irq_ctrl uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_tick();
    tick = 1; step(); tick = 0;
  endtask

  task automatic clear_all();
    clr_we = 1; clr_data = 8'h00; step(); clr_we = 0; clr_data = 8'hFF;
  endtask

  task automatic base();
    stby = 0; per_100ms = 0; per_1s = 0; per_1min = 0; tmr_roll = 0;
    ctrl = 0; pulse_sel = 0; irq_mask = 0; cur_time = NOW; alm_time = ~NOW;
    clear_all();
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 0);
    chk("R1 irq_oe", irq_oe, 0);
    chk("R1 irq_n", irq_n, 1);
  endtask

  task automatic t_pulse();
    base();
    ctrl = 8'h02; irq_mask = 3'b001; pulse_sel = 4'b0001;
    tick = 1; #1;
    chk("R11 flag not before edge", flags, 0);
    @(posedge clk); #1; tick = 0;
    chk("R4 10ms pulse flag", flags, 3'b001);
    chk("R2 irq_oe from pulse", irq_oe, 1);
    chk("R2 irq_n low", irq_n, 0);
    step();
    chk("R2 flag persists", flags, 3'b001);
    clr_we = 1; clr_data = 8'hEF; step(); clr_we = 0; clr_data = 8'hFF;
    chk("R3 clear pulse", flags, 0);
    chk("R2 irq released", irq_oe, 0);
    pulse_sel = 4'b0010; do_tick();
    chk("R4 100ms without strobe", flags, 0);
    per_100ms = 1; do_tick(); per_100ms = 0;
    chk("R4 100ms with strobe", flags, 3'b001);
    clear_all();
    pulse_sel = 4'b1000; per_1s = 1; do_tick(); per_1s = 0;
    chk("R4 1min wrong strobe", flags, 0);
    per_1min = 1; do_tick(); per_1min = 0;
    chk("R4 1min with strobe", flags, 3'b001);
    clear_all();
    pulse_sel = 4'b0011; per_100ms = 1; do_tick(); per_100ms = 0;
    chk("R4 two rates disable", flags, 0);
    pulse_sel = 4'b0000; do_tick();
    chk("R4 no rate", flags, 0);
    pulse_sel = 4'b0001; ctrl = 8'h00; do_tick();
    chk("R5 pulse disabled", flags, 0);
  endtask

  task automatic t_alarm();
    base();
    ctrl = 8'h04; irq_mask = 3'b010; alm_time = NOW;
    do_tick();
    chk("R6 full match", flags, 3'b010);
    chk("R2 irq from alarm", irq_oe, 1);
    clr_we = 1; clr_data = 8'hDF; step(); clr_we = 0; clr_data = 8'hFF;
    chk("R3 clear alarm", flags, 0);
    alm_time[31:24] = 8'h08; do_tick();
    chk("R6 hour mismatch", flags, 0);
    alm_time[31:24] = 8'hFF; do_tick();
    chk("R6 wildcard hour", flags, 3'b010);
    clear_all();
    alm_time = 40'hFFFF_FFFF_00; cur_time[7:0] = 8'h01; do_tick();
    chk("R6 hundredths mismatch", flags, 0);
    cur_time[7:0] = 8'h00; ctrl = 8'h00; do_tick();
    chk("R5 alarm disabled", flags, 0);
  endtask

  task automatic t_timer();
    base();
    ctrl = 8'h08; irq_mask = 3'b000; tmr_roll = 1; step(); tmr_roll = 0;
    chk("R7 roll without tick", flags, 0);
    tmr_roll = 1; do_tick(); tmr_roll = 0;
    chk("R7 rollover sets", flags, 3'b100);
    chk("R2 masked timer", irq_oe, 0);
    irq_mask = 3'b100; #1;
    chk("R2 mask opens irq", irq_oe, 1);
    clr_we = 1; clr_data = 8'h40; step(); clr_we = 0; clr_data = 8'hFF;
    chk("R3 one keeps timer", flags, 3'b100);
    clear_all();
    ctrl = 8'h00; tmr_roll = 1; do_tick(); tmr_roll = 0;
    chk("R5 timer disabled", flags, 0);
  endtask

  task automatic t_standby();
    base();
    ctrl = 8'h0E; irq_mask = 3'b111; pulse_sel = 4'b0001; tmr_roll = 1;
    do_tick(); tmr_roll = 0;
    chk("R8 setup pulse+timer", flags, 3'b101);
    stby = 1; #1;
    chk("R8 standby blocks pulse/timer irq", irq_oe, 0);
    chk("R8 flags kept", flags, 3'b101);
    clear_all();
    tmr_roll = 1; do_tick(); tmr_roll = 0;
    chk("R8 no pulse, timer set in standby", flags, 3'b100);
    chk("R8 timer irq held off", irq_oe, 0);
    alm_time = NOW; do_tick(); alm_time = ~NOW;
    chk("R8 alarm in standby", flags, 3'b110);
    chk("R8 alarm drives irq", irq_oe, 1);
    clear_all();
    stby = 0; do_tick();
    chk("R10 pulse resumes", flags, 3'b001);
    chk("R10 irq after standby", irq_oe, 1);
  endtask

  task automatic t_priority();
    base();
    ctrl = 8'h04; alm_time = NOW;
    tick = 1; clr_we = 1; clr_data = 8'h00; step();
    tick = 0; clr_we = 0; clr_data = 8'hFF;
    chk("R9 set beats clear", flags, 3'b010);
  endtask

  initial begin
    #1;
    chk("R1 flags in reset", flags, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_pulse();
    t_alarm();
    t_timer();
    t_standby();
    t_priority();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule